// File: doc/BRIEF.md
# Processor trace status encoder

This block turns instruction retirement events from a processor core into a real-time trace stream on two 4-bit ports. The status port carries one code per cycle. On retirement the code is 0x1, or 0x5 for a taken conditional branch. A size marker announces each optional operand record or branch-target record. The data port then carries that record's value, one nibble per cycle, starting with the least-significant nibble. On every nibble cycle the status port shows 0x0 (continue).

Each retirement produces one, two or three records. Three control inputs select which optional records are produced: one captures read operands, one captures write operands, and one enables branch-target display. All records wait in a small queue in retirement order. When the queue cannot take three more records, the core is stalled through a ready/valid handshake, so no record is lost. Branch targets are compressed: only the low bytes that differ from the previously displayed target are sent.

Top module: `trace_status_enc`

## Requirements
- R1: An accepted retirement whose class is plain (0), not-taken branch (2), or any unused code (6, 7) produces exactly one record: status code 0x1. A memory read (3), memory write (4) or read-modify-write (5) also produces code 0x1 before any operand record.
- R2: An accepted taken branch (class 1) produces status code 0x5 in place of 0x1.
- R3: Each operand record has a marker and then its nibbles. The size code sets both: 0 means 1 byte with marker 0x8, 1 means 2 bytes with marker 0x9, and 2 or 3 means 4 bytes with marker 0xB. The marker appears on the status port with data 0x0. Then 2×bytes cycles follow with status 0x0, and the data port shows the value's nibbles, least-significant first.
- R4: A memory read emits its read value only while read capture is set. A memory write emits its write value only while write capture is set. When its capture bit is clear, the instruction produces code 0x1 alone.
- R5: A read-modify-write emits its read value first, gated by read capture. It then emits its write value, gated by write capture. Both records use the same size marker, so a byte-sized bit operation uses 0x8 for both.
- R6: A taken branch with target display enabled is followed by a target record. If the target's upper 16 bits equal those of the last displayed target, the record is 2 bytes with marker 0x9. Else, if the upper 8 bits are equal, it is 3 bytes with marker 0xA. Otherwise it is 4 bytes with marker 0xB. Not-taken branches never show a target.
- R7: The last displayed target resets to zero. It changes only when a target record is produced.
- R8: The ready output is high exactly when the queue holds at most DEPTH−3 records. A retirement is accepted only on a clock edge where both valid and ready are high. No record is dropped or duplicated.
- R9: Records leave in the order they were built. When the block is fully idle, the marker of an accepted retirement appears on the status port after the second rising edge that follows acceptance. The records then run back to back, with no gap cycles.
- R10: During and after reset, and in any cycle with no record to output, the status port and the data port are both 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retirement event present |
| ret_ready | output | 1 | Queue can accept a retirement |
| ret_class | input | 3 | Instruction class code |
| opnd_size | input | 2 | Operand size code |
| rd_value | input | 32 | Operand read from memory |
| wr_value | input | 32 | Operand written to memory |
| tgt_addr | input | 32 | Branch target address |
| cap_rd | input | 1 | Capture read operands |
| cap_wr | input | 1 | Capture write operands |
| tgt_en | input | 1 | Display branch targets |
| pst | output | 4 | Trace status code |
| ddata | output | 4 | Trace data nibble |

## Verification
A retirement is accepted on a rising edge and enters the queue at that edge. The serializer takes it at the next edge and registers the marker, so the marker shows on the status port after the second edge. Each nibble of the record then appears one edge later than the one before it. The reference model in the bench advances by one output slot on each rising edge and applies acceptance at the same edge, in the same order as the design. The bench compares status, data and ready at the following falling edge, so every comparison falls mid-cycle, after the edge that is due to produce the value.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int VAL_W    = 32;
    localparam int NIB_W    = 4;
    localparam int MAX_RECS = 3;

    typedef enum logic [2:0] {
        CLS_PLAIN    = 3'd0,
        CLS_BR_TAKEN = 3'd1,
        CLS_BR_NOT   = 3'd2,
        CLS_MEM_RD   = 3'd3,
        CLS_MEM_WR   = 3'd4,
        CLS_RMW      = 3'd5
    } ret_class_e;

    typedef struct packed {
        logic [NIB_W-1:0] marker;
        logic [NIB_W-1:0] nnib;
        logic [VAL_W-1:0] value;
    } trace_rec_t;

    localparam logic [NIB_W-1:0] ST_IDLE   = 4'h0;
    localparam logic [NIB_W-1:0] ST_RETIRE = 4'h1;
    localparam logic [NIB_W-1:0] ST_TAKEN  = 4'h5;
    localparam logic [NIB_W-1:0] MK_1B     = 4'h8;
    localparam logic [NIB_W-1:0] MK_2B     = 4'h9;
    localparam logic [NIB_W-1:0] MK_3B     = 4'hA;
    localparam logic [NIB_W-1:0] MK_4B     = 4'hB;
endpackage

// File: rtl/trace_rec_builder.sv
module trace_rec_builder
    import trace_pkg::*;
(
    input  logic [2:0]          ret_class,
    input  logic [1:0]          opnd_size,
    input  logic [VAL_W-1:0]    rd_value,
    input  logic [VAL_W-1:0]    wr_value,
    input  logic [VAL_W-1:0]    tgt_addr,
    input  logic [VAL_W-1:0]    last_tgt,
    input  logic                cap_rd,
    input  logic                cap_wr,
    input  logic                tgt_en,
    output trace_rec_t [MAX_RECS-1:0] recs,
    output logic [1:0]          n_rec,
    output logic                tgt_shown
);
    logic [NIB_W-1:0] op_mk, op_nn, tg_mk, tg_nn;

    // operand marker and nibble count from the size code
    always_comb begin
        unique case (opnd_size)
            2'd0:    begin op_mk = MK_1B; op_nn = 4'd2; end
            2'd1:    begin op_mk = MK_2B; op_nn = 4'd4; end
            default: begin op_mk = MK_4B; op_nn = 4'd8; end
        endcase
    end

    // shortest target form relative to the last displayed target
    always_comb begin
        if (tgt_addr[VAL_W-1 -: 16] == last_tgt[VAL_W-1 -: 16]) begin
            tg_mk = MK_2B; tg_nn = 4'd4;
        end else if (tgt_addr[VAL_W-1 -: 8] == last_tgt[VAL_W-1 -: 8]) begin
            tg_mk = MK_3B; tg_nn = 4'd6;
        end else begin
            tg_mk = MK_4B; tg_nn = 4'd8;
        end
    end

    always_comb begin
        recs      = '0;
        n_rec     = 2'd1;
        tgt_shown = 1'b0;
        recs[0]   = '{marker: ST_RETIRE, nnib: 4'd0, value: '0};
        unique case (ret_class)
            CLS_BR_TAKEN: begin
                recs[0].marker = ST_TAKEN;
                if (tgt_en) begin
                    recs[1]   = '{marker: tg_mk, nnib: tg_nn, value: tgt_addr};
                    n_rec     = 2'd2;
                    tgt_shown = 1'b1;
                end
            end
            CLS_MEM_RD: begin
                if (cap_rd) begin
                    recs[1] = '{marker: op_mk, nnib: op_nn, value: rd_value};
                    n_rec   = 2'd2;
                end
            end
            CLS_MEM_WR: begin
                if (cap_wr) begin
                    recs[1] = '{marker: op_mk, nnib: op_nn, value: wr_value};
                    n_rec   = 2'd2;
                end
            end
            CLS_RMW: begin
                if (cap_rd && cap_wr) begin
                    recs[1] = '{marker: op_mk, nnib: op_nn, value: rd_value};
                    recs[2] = '{marker: op_mk, nnib: op_nn, value: wr_value};
                    n_rec   = 2'd3;
                end else if (cap_rd) begin
                    recs[1] = '{marker: op_mk, nnib: op_nn, value: rd_value};
                    n_rec   = 2'd2;
                end else if (cap_wr) begin
                    recs[1] = '{marker: op_mk, nnib: op_nn, value: wr_value};
                    n_rec   = 2'd2;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trace_rec_fifo.sv
module trace_rec_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                push_n,
    input  trace_rec_t [MAX_RECS-1:0] push_recs,
    input  logic                      pop,
    output trace_rec_t                head,
    output logic [CNT_W-1:0]          count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        trace_rec_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       wp;
        logic [PTR_W-1:0]       rp;
        logic [CNT_W-1:0]       cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MAX_RECS; i++) begin
            if (i < int'(push_n)) begin
                st_d.mem[st_d.wp] = push_recs[i];
                st_d.wp           = ptr_inc(st_d.wp);
            end
        end
        if (pop) st_d.rp = ptr_inc(st_q.rp);
        st_d.cnt = st_q.cnt + CNT_W'(push_n) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/trace_nib_serializer.sv
module trace_nib_serializer
    import trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  trace_rec_t       head,
    input  logic             has_data,
    output logic             pop,
    output logic [NIB_W-1:0] pst,
    output logic [NIB_W-1:0] ddata,
    output logic             busy
);
    typedef struct packed {
        logic [VAL_W-1:0] sh;
        logic [NIB_W-1:0] rem;
        logic [NIB_W-1:0] pst;
        logic [NIB_W-1:0] dd;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (st_q.rem != '0) begin
            st_d.pst = ST_IDLE;
            st_d.dd  = st_q.sh[NIB_W-1:0];
            st_d.sh  = st_q.sh >> NIB_W;
            st_d.rem = st_q.rem - 1'b1;
        end else if (has_data) begin
            pop      = 1'b1;
            st_d.pst = head.marker;
            st_d.dd  = '0;
            st_d.sh  = head.value;
            st_d.rem = head.nnib;
        end else begin
            st_d.pst = ST_IDLE;
            st_d.dd  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pst   = st_q.pst;
    assign ddata = st_q.dd;
    assign busy  = (st_q.rem != '0);
endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc
    import trace_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    output logic             ret_ready,
    input  logic [2:0]       ret_class,
    input  logic [1:0]       opnd_size,
    input  logic [VAL_W-1:0] rd_value,
    input  logic [VAL_W-1:0] wr_value,
    input  logic [VAL_W-1:0] tgt_addr,
    input  logic             cap_rd,
    input  logic             cap_wr,
    input  logic             tgt_en,
    output logic [NIB_W-1:0] pst,
    output logic [NIB_W-1:0] ddata
);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int ROOM_MAX = DEPTH - MAX_RECS;

    typedef struct packed {
        logic [VAL_W-1:0] last_tgt;
    } top_st_t;

    top_st_t st_d, st_q;

    trace_rec_t [MAX_RECS-1:0] new_recs;
    trace_rec_t                head;
    logic [1:0]                n_rec, push_n;
    logic                      tgt_shown, accept, pop, ser_busy;
    logic [CNT_W-1:0]          fifo_cnt;

    assign ret_ready = (fifo_cnt <= CNT_W'(ROOM_MAX));
    assign accept    = ret_valid && ret_ready;
    assign push_n    = accept ? n_rec : 2'd0;

    always_comb begin
        st_d = st_q;
        if (accept && tgt_shown) st_d.last_tgt = tgt_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    trace_rec_builder u_build (
        .ret_class (ret_class),
        .opnd_size (opnd_size),
        .rd_value  (rd_value),
        .wr_value  (wr_value),
        .tgt_addr  (tgt_addr),
        .last_tgt  (st_q.last_tgt),
        .cap_rd    (cap_rd),
        .cap_wr    (cap_wr),
        .tgt_en    (tgt_en),
        .recs      (new_recs),
        .n_rec     (n_rec),
        .tgt_shown (tgt_shown)
    );

    trace_rec_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (push_n),
        .push_recs (new_recs),
        .pop       (pop),
        .head      (head),
        .count     (fifo_cnt)
    );

    trace_nib_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .head     (head),
        .has_data (fifo_cnt != '0),
        .pop      (pop),
        .pst      (pst),
        .ddata    (ddata),
        .busy     (ser_busy)
    );
endmodule

// File: rtl/trace_status_enc_chk.sv
module trace_status_enc_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic             ret_ready,
    input logic [3:0]       pst,
    input logic [3:0]       ddata,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             ser_busy
);
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    a_r8_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_ready) |=> (fifo_cnt <= $past(fifo_cnt)));

    a_r1_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        pst inside {4'h0, 4'h1, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB});

    a_r3_marker_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pst != 4'h0) |-> (ddata == 4'h0));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && !ser_busy) |=> (pst == 4'h0 && ddata == 4'h0));

    a_r9_prompt_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_ready && fifo_cnt == '0 && !ser_busy) |=> ##1 (pst != 4'h0));
endmodule

bind trace_status_enc trace_status_enc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_valid (ret_valid),
    .ret_ready (ret_ready),
    .pst       (pst),
    .ddata     (ddata),
    .fifo_cnt  (fifo_cnt),
    .ser_busy  (ser_busy)
);

// File: tb/trace_status_enc_tb_top.sv
module trace_status_enc_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic        ret_ready;
    logic [2:0]  ret_class = '0;
    logic [1:0]  opnd_size = '0;
    logic [31:0] rd_value = '0, wr_value = '0, tgt_addr = '0;
    logic        cap_rd = 1'b0, cap_wr = 1'b0, tgt_en = 1'b0;
    logic [3:0]  pst, ddata;

    always #4 clk = ~clk;

    trace_status_enc #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_class(ret_class), .opnd_size(opnd_size), .rd_value(rd_value),
        .wr_value(wr_value), .tgt_addr(tgt_addr), .cap_rd(cap_rd), .cap_wr(cap_wr),
        .tgt_en(tgt_en), .pst(pst), .ddata(ddata)
    );

    int tests = 0, fails = 0, stalls = 0;
    bit started = 0, done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // behavioural reference model
    typedef struct {
        int          marker;
        int          nbytes;
        logic [31:0] val;
        string       tag;
    } mrec_t;

    mrec_t       q[$];
    int          m_rem = 0;
    logic [31:0] m_sh = '0, m_last = '0;
    string       m_tag = "R10", exp_tag = "R10";
    int          exp_pst = 0, exp_dd = 0;

    function automatic int size_bytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic int op_marker(input int b);
        return (b == 1) ? 8 : (b == 2) ? 9 : 11;
    endfunction

    task automatic mpush(input int mk, input int nb, input logic [31:0] v, input string tg);
        mrec_t r;
        r.marker = mk; r.nbytes = nb; r.val = v; r.tag = tg;
        q.push_back(r);
    endtask

    task automatic model_accept();
        int b, tb;
        b = size_bytes(opnd_size);
        mpush((ret_class == 3'd1) ? 5 : 1, 0, '0, (ret_class == 3'd1) ? "R2" : "R1");
        case (ret_class)
            3'd1: if (tgt_en) begin
                if (tgt_addr[31:16] == m_last[31:16]) tb = 2;
                else if (tgt_addr[31:24] == m_last[31:24]) tb = 3;
                else tb = 4;
                mpush(tb + 7, tb, tgt_addr, "R6 R7");
                m_last = tgt_addr;
            end
            3'd3: if (cap_rd) mpush(op_marker(b), b, rd_value, "R3 R4");
            3'd4: if (cap_wr) mpush(op_marker(b), b, wr_value, "R3 R4");
            3'd5: begin
                if (cap_rd) mpush(op_marker(b), b, rd_value, "R5 src");
                if (cap_wr) mpush(op_marker(b), b, wr_value, "R5 dst");
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_rem = 0; m_last = '0; exp_pst = 0; exp_dd = 0; exp_tag = "R10";
        end else begin
            bit acc;
            acc = ret_valid && (q.size() <= DEPTH - 3);
            if (ret_valid && !acc) stalls++;
            if (m_rem > 0) begin
                exp_pst = 0; exp_dd = int'(m_sh[3:0]); m_sh = m_sh >> 4; m_rem--; exp_tag = m_tag;
            end else if (q.size() > 0) begin
                mrec_t r;
                r = q.pop_front();
                exp_pst = r.marker; exp_dd = 0; m_sh = r.val; m_rem = 2 * r.nbytes;
                exp_tag = r.tag; m_tag = {"R9 ", r.tag};
            end else begin
                exp_pst = 0; exp_dd = 0; exp_tag = "R10";
            end
            if (acc) model_accept();
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check(pst == 4'(exp_pst), {exp_tag, " pst"}, int'(pst), exp_pst);
            check(ddata == 4'(exp_dd), {exp_tag, " ddata"}, int'(ddata), exp_dd);
            check(ret_ready == (q.size() <= DEPTH - 3), "R8 ready", int'(ret_ready),
                  int'(q.size() <= DEPTH - 3));
        end
    end

    task automatic retire(input logic [2:0] c, input logic [1:0] s, input logic [31:0] rv,
                          input logic [31:0] wv, input logic [31:0] ta);
        @(negedge clk);
        ret_valid = 1'b1; ret_class = c; opnd_size = s;
        rd_value = rv; wr_value = wv; tgt_addr = ta;
        do @(posedge clk); while (!ret_ready);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        ret_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(pst == 4'h0 && ddata == 4'h0, "R10 reset outputs", int'({pst, ddata}), 0);
        check(ret_ready == 1'b1, "R8 ready after reset", int'(ret_ready), 1);
        started = 1;

        // R1: plain, not-taken, uncaptured memory accesses
        retire(3'd0, 2'd2, 32'h11111111, 32'h0, 32'h0);
        retire(3'd2, 2'd0, 32'h0, 32'h0, 32'h00400000);
        retire(3'd3, 2'd2, 32'hDEADBEEF, 32'h0, 32'h0);
        retire(3'd6, 2'd0, 32'h0, 32'h0, 32'h0);
        // R2: taken branch, target display off
        retire(3'd1, 2'd0, 32'h0, 32'h0, 32'h12345678);
        idle(6);

        // R3 R4: read capture only, all sizes; write stays silent
        cap_rd = 1'b1;
        retire(3'd3, 2'd0, 32'hA5A5A5C3, 32'h0, 32'h0);
        retire(3'd3, 2'd1, 32'h0000BEEF, 32'h0, 32'h0);
        retire(3'd3, 2'd2, 32'h87654321, 32'h0, 32'h0);
        retire(3'd4, 2'd2, 32'h0, 32'hCAFEF00D, 32'h0);
        idle(30);
        // R4 R5: write capture only
        cap_rd = 1'b0; cap_wr = 1'b1;
        retire(3'd4, 2'd3, 32'h0, 32'h13579BDF, 32'h0);
        retire(3'd5, 2'd0, 32'h000000AA, 32'h00000055, 32'h0);
        retire(3'd3, 2'd0, 32'h000000FF, 32'h0, 32'h0);
        idle(30);
        // R5: byte-sized bit operation, both records
        cap_rd = 1'b1;
        retire(3'd5, 2'd0, 32'h0000003C, 32'h0000007C, 32'h0);
        retire(3'd5, 2'd1, 32'h00001234, 32'h00005678, 32'h0);
        idle(30);

        // R6 R7: target compression against last shown target
        tgt_en = 1'b1;
        retire(3'd1, 2'd0, 32'h0, 32'h0, 32'h12345678);
        retire(3'd1, 2'd0, 32'h0, 32'h0, 32'h1234ABCD);
        retire(3'd2, 2'd0, 32'h0, 32'h0, 32'hFFFF0000);
        retire(3'd1, 2'd0, 32'h0, 32'h0, 32'h12FF0000);
        retire(3'd1, 2'd0, 32'h0, 32'h0, 32'h80000000);
        idle(40);

        // R8 R9: back-to-back long read-modify-writes force a stall
        stalls = 0;
        for (int i = 0; i < 8; i++)
            retire(3'd5, 2'd2, 32'h01020304 * (i + 1), 32'hF0E0D0C0 ^ i, 32'h0);
        idle(200);
        check(stalls > 0, "R8 stall observed", stalls, 1);
        check(pst == 4'h0 && ddata == 4'h0, "R10 drained idle", int'({pst, ddata}), 0);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end
endmodule